// File: doc/BRIEF.md
# PHY Lane Override Sequencer

After a link reset, this block takes over the receive and transmit controls of one lane in a multi-lane serial PHY. It issues read-modify-write steps through a single register request port. The port carries an address, write data, a read/write flag and a valid signal. The access engine behind it answers with a done strobe and read data.

A full run has three phases:

- **Receive phase.** The sequencer first waits until the lane leaves half-rate. It then takes manual control of the receiver, programs the DPLL mode field and pulses the DPLL reset.
- **Settle.** It waits for a configurable settle time.
- **Transmit phase.** Unless the attenuation input marks the value as unused, it takes control of the transmitter and merges the attenuation into the override register.

A second entry point only hands receive control back to the PHY. If no PHY exists for the lane (the valid input is low), the sequencer finishes at once and makes no access.

Top module: `lane_ovr_seq`

## Requirements
- R1: After reset, busy_o, done_o, req_valid_o and timeout_o are all 0.
- R2: Register addresses are the register code plus lane × 0x100. The codes are 0x2001 (TX status), 0x2002 (RX status), 0x2004 (TX override) and 0x2005 (RX override).
- R3: A full run starts by reading RX status again and again while bit 0 (half-rate) reads 1, with at most POLL_LIMIT reads. If the last permitted read still shows bit 0 set, the run continues and timeout_o is set. timeout_o is cleared when the next run is accepted.
- R4: After polling, RX status is read once more into value S. The writes to RX override are then, in order:
  - S with bit 14 cleared;
  - the previous value with bit 14 set;
  - the previous value with bits 10:8 replaced by mode_i;
  - the previous value with bit 11 set;
  - the previous value with bit 11 cleared.
- R5: After the last RX override write completes, no request is issued and done_o stays low for at least SETTLE_CYC cycles.
- R6: When atten_i bit 3 is 1, the run makes no TX access and ends after the settle time.
- R7: Otherwise, TX status is read into value T. The writes to TX override are then, in order:
  - T with bit 15 cleared;
  - the previous value with bit 15 set;
  - the previous value ORed with atten_i[2:0] shifted to bits 12:10.
- R8: A clr_i request makes exactly two accesses with no polling: one RX status read giving S, then one RX override write of S with bit 14 cleared.
- R9: If cfg_valid_i is 0 when a request is accepted, done_o is 1 in the next cycle and no access is made.
- R10: While req_valid_o is 1 and req_done_i is 0, the address, direction and write data stay unchanged.
- R11: done_o is a one-cycle pulse, and busy_o is 0 in the cycle after it. start_i and clr_i have no effect while busy_o is 1. start_i wins over clr_i.
- R12: Lane, mode and attenuation are captured when a request is accepted. Later changes to those inputs do not affect the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a full override run |
| clr_i | input | 1 | Request a receive-override release only |
| cfg_valid_i | input | 1 | A PHY is present for the lane |
| lane_i | input | 2 | Lane index |
| mode_i | input | 3 | Receive DPLL mode value |
| atten_i | input | 4 | Transmit attenuation; bit 3 set means skip |
| req_valid_o | output | 1 | Register request pending |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Register address |
| req_wdata_o | output | DATA_W | Write data |
| req_done_i | input | 1 | Access engine completed the request |
| req_rdata_i | input | DATA_W | Read data, valid with req_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Half-rate poll exhausted in the last run |

## Verification
A wrong state or working value shows up at the request port, at the very next access. It appears as a wrong address, a wrong direction or a wrong bit in the merged write data. Each access is therefore compared against an independently computed list as soon as it appears. A wrong poll count shows up as extra or missing RX status reads and as a wrong timeout_o at the end of the run. A settle counter that ends too early shows up as a short gap before the next request or before done_o.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_POLL, ST_RX_RD, ST_RX_W0, ST_RX_W1, ST_RX_W2, ST_RX_W3,
        ST_RX_W4, ST_SETTLE, ST_TX_RD, ST_TX_W0, ST_TX_W1, ST_TX_W2, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_TX_STS, RG_RX_STS, RG_TX_OVR, RG_RX_OVR
    } reg_sel_e;

    localparam int HALF_BIT    = 0;
    localparam int MODE_LSB    = 8;
    localparam int ATT_LSB     = 10;
    localparam int DPLL_RST    = 11;
    localparam int RX_OVR_BIT  = 14;
    localparam int TX_OVR_BIT  = 15;
endpackage

// File: rtl/lane_ovr_addr.sv
module lane_ovr_addr
    import lane_ovr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 2
) (
    input  reg_sel_e            sel_i,
    input  logic [LANE_W-1:0]   lane_i,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(32'h100);
    logic [ADDR_W-1:0] base;

    always_comb begin
        case (sel_i)
            RG_TX_STS: base = ADDR_W'(32'h2001);
            RG_RX_STS: base = ADDR_W'(32'h2002);
            RG_TX_OVR: base = ADDR_W'(32'h2004);
            default:   base = ADDR_W'(32'h2005);
        endcase
        addr_o = base + ADDR_W'(lane_i) * STRIDE;
    end
endmodule

// File: rtl/lane_ovr_timer.sv
module lane_ovr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             running_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign running_o = (cnt_q != '0);
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
    import lane_ovr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 1000,
    parameter int SETTLE_CYC = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clr_i,
    input  logic              cfg_valid_i,
    input  logic [1:0]        lane_i,
    input  logic [2:0]        mode_i,
    input  logic [3:0]        atten_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              req_done_i,
    input  logic [DATA_W-1:0] req_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);
    localparam int ST_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        lane;
        logic [2:0]        mode;
        logic [3:0]        atten;
        logic              clr_only;
        logic [DATA_W-1:0] tmp;
        logic [PC_W-1:0]   poll;
        logic              tout;
    } ctx_t;

    ctx_t     ctx_d, ctx_q;
    logic     settle_load, settle_run;
    reg_sel_e sel;
    logic     vld, wr;
    logic [DATA_W-1:0] wd;

    always_comb begin
        ctx_d       = ctx_q;
        settle_load = 1'b0;
        vld         = 1'b0;
        wr          = 1'b0;
        sel         = RG_RX_STS;
        wd          = ctx_q.tmp;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start_i || clr_i) begin
                    ctx_d.lane     = lane_i;
                    ctx_d.mode     = mode_i;
                    ctx_d.atten    = atten_i;
                    ctx_d.clr_only = !start_i;
                    ctx_d.poll     = '0;
                    ctx_d.tout     = 1'b0;
                    if (!cfg_valid_i) ctx_d.st = ST_DONE;
                    else if (start_i) ctx_d.st = ST_POLL;
                    else              ctx_d.st = ST_RX_RD;
                end
            end
            ST_POLL: begin
                vld = 1'b1;
                if (req_done_i) begin
                    ctx_d.poll = ctx_q.poll + 1'b1;
                    if (!req_rdata_i[HALF_BIT]) begin
                        ctx_d.st = ST_RX_RD;
                    end else if (ctx_q.poll == PC_W'(POLL_LIMIT - 1)) begin
                        ctx_d.tout = 1'b1;
                        ctx_d.st   = ST_RX_RD;
                    end
                end
            end
            ST_RX_RD: begin
                vld = 1'b1;
                if (req_done_i) begin
                    ctx_d.tmp = req_rdata_i;
                    ctx_d.st  = ST_RX_W0;
                end
            end
            ST_RX_W0, ST_RX_W1, ST_RX_W2, ST_RX_W3, ST_RX_W4: begin
                vld = 1'b1;
                wr  = 1'b1;
                sel = RG_RX_OVR;
                case (ctx_q.st)
                    ST_RX_W0: wd[RX_OVR_BIT] = 1'b0;
                    ST_RX_W1: wd[RX_OVR_BIT] = 1'b1;
                    ST_RX_W2: wd[MODE_LSB +: 3] = ctx_q.mode;
                    ST_RX_W3: wd[DPLL_RST] = 1'b1;
                    default:  wd[DPLL_RST] = 1'b0;
                endcase
                if (req_done_i) begin
                    ctx_d.tmp = wd;
                    case (ctx_q.st)
                        ST_RX_W0: ctx_d.st = ctx_q.clr_only ? ST_DONE : ST_RX_W1;
                        ST_RX_W1: ctx_d.st = ST_RX_W2;
                        ST_RX_W2: ctx_d.st = ST_RX_W3;
                        ST_RX_W3: ctx_d.st = ST_RX_W4;
                        default: begin
                            ctx_d.st    = ST_SETTLE;
                            settle_load = 1'b1;
                        end
                    endcase
                end
            end
            ST_SETTLE: begin
                if (!settle_run)
                    ctx_d.st = ctx_q.atten[3] ? ST_DONE : ST_TX_RD;
            end
            ST_TX_RD: begin
                vld = 1'b1;
                sel = RG_TX_STS;
                if (req_done_i) begin
                    ctx_d.tmp = req_rdata_i;
                    ctx_d.st  = ST_TX_W0;
                end
            end
            ST_TX_W0, ST_TX_W1, ST_TX_W2: begin
                vld = 1'b1;
                wr  = 1'b1;
                sel = RG_TX_OVR;
                case (ctx_q.st)
                    ST_TX_W0: wd[TX_OVR_BIT] = 1'b0;
                    ST_TX_W1: wd[TX_OVR_BIT] = 1'b1;
                    default:  wd = ctx_q.tmp | (DATA_W'(ctx_q.atten[2:0]) << ATT_LSB);
                endcase
                if (req_done_i) begin
                    ctx_d.tmp = wd;
                    case (ctx_q.st)
                        ST_TX_W0: ctx_d.st = ST_TX_W1;
                        ST_TX_W1: ctx_d.st = ST_TX_W2;
                        default:  ctx_d.st = ST_DONE;
                    endcase
                end
            end
            ST_DONE: ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q          <= '0;
            ctx_q.st       <= ST_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    lane_ovr_timer #(.CNT_W(ST_W)) settle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (settle_load),
        .load_val_i (ST_W'(SETTLE_CYC)),
        .running_o  (settle_run)
    );

    lane_ovr_addr #(.ADDR_W(ADDR_W), .LANE_W(2)) addr_i (
        .sel_i  (sel),
        .lane_i (ctx_q.lane),
        .addr_o (req_addr_o)
    );

    assign req_valid_o = vld;
    assign req_write_o = wr;
    assign req_wdata_o = wd;
    assign busy_o      = (ctx_q.st != ST_IDLE);
    assign done_o      = (ctx_q.st == ST_DONE);
    assign timeout_o   = ctx_q.tout;

    // R10: request fields held until the engine completes it
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_done_i) |=> (req_valid_o && $stable(req_addr_o)
            && $stable(req_write_o) && $stable(req_wdata_o)));

    // R11: completion is a single-cycle pulse followed by idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R5: the settle counter keeps the request port quiet
    a_r5_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        settle_run |-> (!req_valid_o && !done_o));

    // R2: only the four lane register codes are ever addressed
    a_r2_addr_map: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o[7:3] == 5'd0 && (req_addr_o[2:0] == 3'd1 ||
            req_addr_o[2:0] == 3'd2 || req_addr_o[2:0] == 3'd4 || req_addr_o[2:0] == 3'd5)));
endmodule

// File: tb/lane_ovr_seq_tb.sv
module lane_ovr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PL         = 8;
    localparam int SETTLE     = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, clr_i = 1'b0, cfg_valid_i = 1'b1;
    logic [1:0] lane_i = '0;
    logic [2:0] mode_i = '0;
    logic [3:0] atten_i = '0;
    logic req_valid_o, req_write_o;
    logic [15:0] req_addr_o, req_wdata_o;
    logic req_done_i = 1'b0;
    logic [15:0] req_rdata_i = '0;
    logic busy_o, done_o, timeout_o;

    lane_ovr_seq #(.ADDR_W(16), .DATA_W(16), .POLL_LIMIT(PL), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i),
        .cfg_valid_i(cfg_valid_i), .lane_i(lane_i), .mode_i(mode_i), .atten_i(atten_i),
        .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_addr_o(req_addr_o),
        .req_wdata_o(req_wdata_o), .req_done_i(req_done_i), .req_rdata_i(req_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, fails = 0, cyc = 0;
    int rx_sts[4], tx_sts[4], half_left[4];
    int exp_addr[$], exp_wr[$], exp_data[$];
    int rs = 0, cap_addr, cap_wr, cap_data;
    int rx_w_cyc = 0, tx_rd_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register-port responder: two-cycle latency, records and compares each access
    always @(negedge clk) begin
        if (rst_n) begin
            case (rs)
                0: if (req_valid_o) begin
                    int ln, code;
                    cap_addr = req_addr_o; cap_wr = req_write_o; cap_data = req_wdata_o;
                    ln = (cap_addr - 'h2000) >> 8; code = cap_addr & 'hff;
                    if (exp_addr.size() == 0) begin
                        chk("R11 unexpected access", cap_addr, 0);
                    end else begin
                        int ea, ew, ed;
                        ea = exp_addr.pop_front(); ew = exp_wr.pop_front(); ed = exp_data.pop_front();
                        chk("R2 address", cap_addr, ea);
                        chk("R4/R7/R8 direction", cap_wr, ew);
                        if (ew == 1) chk("R4/R7/R8 write data", cap_data, ed);
                    end
                    if (code == 5 && cap_wr == 1) rx_w_cyc = cyc;
                    if (code == 1 && cap_wr == 0) tx_rd_cyc = cyc;
                    if (code == 2) begin
                        if (half_left[ln & 3] > 0) begin
                            req_rdata_i = 16'(rx_sts[ln & 3] | 1);
                            half_left[ln & 3]--;
                        end else req_rdata_i = 16'(rx_sts[ln & 3] & 'hfffe);
                    end else if (code == 1) req_rdata_i = 16'(tx_sts[ln & 3]);
                    else req_rdata_i = '0;
                    rs = 1;
                end
                1: begin
                    chk("R10 request stable", int'({req_valid_o, req_write_o, req_addr_o, req_wdata_o}),
                        int'({1'b1, cap_wr[0], cap_addr[15:0], cap_data[15:0]}));
                    req_done_i = 1'b1; rs = 2;
                end
                default: begin req_done_i = 1'b0; rs = 0; end
            endcase
        end
    end

    task automatic push(int a, int w, int d);
        exp_addr.push_back(a); exp_wr.push_back(w); exp_data.push_back(d);
    endtask

    task automatic finish_job(bit exp_tout, bit chk_settle, int atten);
        int n = 0, done_at;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        done_at = cyc;
        chk("R11 done seen", int'(done_o), 1);
        if (chk_settle) begin
            int endp = atten[3] ? done_at : tx_rd_cyc;
            chk("R5 settle gap", int'(endp - rx_w_cyc >= SETTLE), 1);
            chk("R6/R7 TX access presence", int'(tx_rd_cyc > rx_w_cyc), atten[3] ? 0 : 1);
        end
        @(negedge clk);
        chk("R11 done one cycle", int'(done_o), 0);
        chk("R11 idle after done", int'(busy_o), 0);
        chk("R3 timeout flag", int'(timeout_o), int'(exp_tout));
        repeat (10) @(negedge clk);
        chk("R11 no leftover accesses", exp_addr.size(), 0);
        chk("R11 port quiet", int'(req_valid_o), 0);
    endtask

    task automatic run_full(int lane, int mode, int atten, int half_n, int rxv, int txv, bit poke);
        int nr, rem, s, t, base;
        base = lane * 'h100;
        rx_sts[lane] = rxv; tx_sts[lane] = txv; half_left[lane] = half_n;
        nr = (half_n + 1 < PL) ? half_n + 1 : PL;
        rem = half_n - nr;
        for (int i = 0; i < nr; i++) push('h2002 + base, 0, 0);
        push('h2002 + base, 0, 0);
        s = (rem > 0) ? (rxv | 1) : (rxv & 'hfffe);
        s = s & ~'h4000;           push('h2005 + base, 1, s);
        s = s | 'h4000;            push('h2005 + base, 1, s);
        s = (s & ~'h700) | (mode << 8); push('h2005 + base, 1, s);
        s = s | 'h800;             push('h2005 + base, 1, s);
        s = s & ~'h800;            push('h2005 + base, 1, s);
        if ((atten & 8) == 0) begin
            t = txv;               push('h2001 + base, 0, 0);
            t = t & ~'h8000;       push('h2004 + base, 1, t);
            t = t | 'h8000;        push('h2004 + base, 1, t);
            t = t | ((atten & 7) << 10); push('h2004 + base, 1, t);
        end
        rx_w_cyc = 0; tx_rd_cyc = 0;
        cfg_valid_i = 1'b1;
        lane_i = 2'(lane); mode_i = 3'(mode); atten_i = 4'(atten); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lane_i = ~lane_i; mode_i = ~mode_i; atten_i = ~atten_i;   // R12: inputs change mid-run
        if (poke) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1; clr_i = 1'b1;                      // R11: ignored while busy
            @(negedge clk);
            start_i = 1'b0; clr_i = 1'b0;
        end
        finish_job(half_n >= PL, 1'b1, atten);
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        chk("watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin rx_sts[i] = 0; tx_sts[i] = 0; half_left[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", int'(busy_o), 0);
        chk("R1 done at reset", int'(done_o), 0);
        chk("R1 valid at reset", int'(req_valid_o), 0);
        chk("R1 timeout at reset", int'(timeout_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_full(0, 3, 5, 2, 'h1234, 'h5a5a, 1'b0);      // R3 R4 R5 R7
        run_full(3, 5, 'hb, 0, 'hffff, 'h0000, 1'b0);   // R6, lane 3
        run_full(1, 6, 2, 12, 'h4701, 'hffff, 1'b0);    // R3 timeout
        run_full(2, 1, 7, 1, 'h0c00, 'h9c00, 1'b1);     // R11 R12

        // R8: release-only entry, previous timeout cleared
        begin
            run_full(1, 0, 0, 20, 0, 0, 1'b0);
            half_left[2] = 0; rx_sts[2] = 'h7fff;
            push('h2202, 0, 0);
            push('h2205, 1, 'h7fff & 'hfffe & ~'h4000);
            mode_i = 3'd7; lane_i = 2'd2; clr_i = 1'b1;
            @(negedge clk);
            clr_i = 1'b0;
            finish_job(1'b0, 1'b0, 0);
        end

        // R9: no PHY configured
        cfg_valid_i = 1'b0; lane_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 done next cycle", int'(done_o), 1);
        repeat (10) @(negedge clk);
        chk("R9 no access", int'(req_valid_o), 0);
        chk("R9 idle", int'(busy_o), 0);
        cfg_valid_i = 1'b1;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule